// File: doc/BRIEF.md
# Almost-Flag Offset Loader

This block holds the two threshold offsets that a FIFO's almost-empty and almost-full flags compare against. During a master reset it reads a two-bit select and a mode input. A nonzero select loads one of three preset offset pairs straight away. A zero select leaves the offsets to be programmed after reset. In that case they are written either from the write data bus or bit by bit through a one-bit serial input, depending on the mode.

Until programming completes, the block holds back ordinary FIFO writes. Once it completes, a done flag rises and writes are passed to the FIFO. A partial reset, which only flushes the FIFO, leaves the offsets, the done flag and any programming in progress untouched.

Top module: `almost_offset_loader`

## Requirements
- R1: While `mrst_n` is low, the select code is decoded at each rising clock edge as follows: `sel` = 2'b01 gives both offsets 8, 2'b10 gives both 16 and 2'b11 gives both 64, each clamped to DEPTH-1, and `load_done` is 1. `sel` = 2'b00 gives both offsets 0 and `load_done` is 0.
- R2: After a reset with `sel` = 2'b00 and `serial_mode` = 0, the first clock with `wr_en` high loads `ae_off` from `wr_data`. The second such clock loads `af_off` and sets `load_done`. Before that, `load_done` stays 0.
- R3: After a reset with `sel` = 2'b00 and `serial_mode` = 1, each clock with `ser_en` high shifts in one `ser_din` bit, most significant bit first. The first AW+1 bits form `ae_off` and the next AW+1 bits form `af_off`, where AW = log2(DEPTH). `load_done` rises on the clock that takes the last bit.
- R4: A loaded value at or above DEPTH is stored as DEPTH-1. For the parallel path this compares the whole `wr_data` word; for the serial path it compares the whole AW+1 bit field.
- R5: `wr_allow` equals `wr_en` when `load_done` is 1 and `prst_n` is 1, and is 0 otherwise.
- R6: While `prst_n` is low, the offsets, `load_done` and the programming progress keep their values, and `wr_en` and `ser_en` have no effect on them.
- R7: Once `load_done` is 1 and master reset stays high, the offsets do not change, whatever `wr_en`, `wr_data`, `ser_en` or `ser_din` do.
- R8: In parallel programming, `ser_en` is ignored. In serial programming, `wr_en` does not advance loading.
- R9: `sel` and `serial_mode` are only read while `mrst_n` is low. Changing them afterwards has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| mrst_n | input | 1 | Synchronous master reset, active low; samples `sel` and `serial_mode` |
| prst_n | input | 1 | Synchronous partial (flush) reset, active low |
| sel | input | 2 | Preset/programming select, decoded during master reset |
| serial_mode | input | 1 | 1 = serial programming, 0 = parallel programming |
| wr_en | input | 1 | FIFO write request; also the parallel load strobe |
| wr_data | input | DW | Write data; parallel offset value |
| ser_en | input | 1 | Serial shift enable |
| ser_din | input | 1 | Serial offset data bit |
| ae_off | output | AW | Almost-empty offset |
| af_off | output | AW | Almost-full offset |
| load_done | output | 1 | Offsets are valid |
| wr_allow | output | 1 | Write request passed on to the FIFO |

## Verification
The table covers every select code, including a preset code with the serial mode set. It separates the three presets from each other and from programmed loads, and shows that a preset wins over the mode input. Parallel and serial loads are run with values below DEPTH and at or above it, so that a clamp that fails to trigger or triggers wrongly shows up. Asymmetric bit patterns in the serial loads also catch a reversed bit order or a swap of the two offsets. Directed cases then give strobes to the path that is not selected, apply partial resets in the middle of a load and after it, and change the select after reset. These separate a block that ignores those inputs from one that reacts to them.

// File: rtl/almost_offset_loader.sv
module almost_offset_loader #(
  parameter int DEPTH = 1024,
  parameter int DW = 36,
  localparam int AW = $clog2(DEPTH),
  localparam int SW = AW + 1,
  localparam int CW = $clog2(2 * SW)
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic [1:0]    sel,
  input  logic          serial_mode,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          ser_en,
  input  logic          ser_din,
  output logic [AW-1:0] ae_off,
  output logic [AW-1:0] af_off,
  output logic          load_done,
  output logic          wr_allow
);

  localparam logic [DW-1:0] DEPTH_W = DW'(DEPTH);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] clamp(input logic [DW-1:0] v);
    return (v >= DEPTH_W) ? TOP : v[AW-1:0];
  endfunction

  logic          ser_q;
  logic          phase_q;
  logic [SW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] preset;

  wire go       = prst_n && !load_done;
  wire par_step = go && !ser_q && wr_en;
  wire ser_step = go && ser_q && ser_en;
  wire [SW-1:0] sh_nx = {sh_q[SW-2:0], ser_din};
  wire [DW-1:0] sh_ext = {{(DW-SW){1'b0}}, sh_nx};

  always_comb begin
    case (sel)
      2'b01:   preset = clamp(DW'(8));
      2'b10:   preset = clamp(DW'(16));
      2'b11:   preset = clamp(DW'(64));
      default: preset = '0;
    endcase
  end

  assign wr_allow = wr_en && load_done && prst_n;

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      ser_q     <= serial_mode;
      phase_q   <= 1'b0;
      sh_q      <= '0;
      cnt_q     <= '0;
      ae_off    <= preset;
      af_off    <= preset;
      load_done <= (sel != 2'b00);
    end else begin
      if (par_step) begin
        phase_q <= 1'b1;
        if (!phase_q) begin
          ae_off <= clamp(wr_data);
        end else begin
          af_off    <= clamp(wr_data);
          load_done <= 1'b1;
        end
      end
      if (ser_step) begin
        sh_q  <= sh_nx;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(SW - 1)) ae_off <= clamp(sh_ext);
        if (cnt_q == CW'(2 * SW - 1)) begin
          af_off    <= clamp(sh_ext);
          load_done <= 1'b1;
        end
      end
    end
  end

  assert_par_waits_R2: assert property (@(posedge clk) disable iff (!mrst_n)
    (!load_done && !ser_q && !wr_en) |=> (!load_done && $stable(ae_off) && $stable(af_off)));

  assert_ser_waits_R3: assert property (@(posedge clk) disable iff (!mrst_n)
    (!load_done && ser_q && !ser_en) |=> (!load_done && $stable(ae_off) && $stable(af_off)));

  assert_flush_keeps_R6: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> ($stable(ae_off) && $stable(af_off) && $stable(load_done)));

  assert_locked_R7: assert property (@(posedge clk) disable iff (!mrst_n)
    load_done |=> (load_done && $stable(ae_off) && $stable(af_off)));

endmodule

// File: tb/almost_offset_loader_tb.sv
module almost_offset_loader_tb_top;
  localparam int DEPTH = 1024;
  localparam int DW = 36;
  localparam int AW = 10;
  localparam int SW = 11;

  logic clk = 0, mrst_n = 0, prst_n = 1, serial_mode = 0;
  logic wr_en = 0, ser_en = 0, ser_din = 0;
  logic [1:0] sel = 0;
  logic [DW-1:0] wr_data = 0;
  logic [AW-1:0] ae_off, af_off;
  logic load_done, wr_allow;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  almost_offset_loader #(.DEPTH(DEPTH), .DW(DW)) dut_i (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .sel(sel),
    .serial_mode(serial_mode), .wr_en(wr_en), .wr_data(wr_data),
    .ser_en(ser_en), .ser_din(ser_din), .ae_off(ae_off), .af_off(af_off),
    .load_done(load_done), .wr_allow(wr_allow));

  // {sel, mode, ae_in, af_in, exp_ae, exp_af}
  localparam logic [63:0] VEC [8] = '{
    {4'h1, 4'h0, 16'h0000, 16'h0000, 12'h008, 12'h008},
    {4'h2, 4'h0, 16'h0000, 16'h0000, 12'h010, 12'h010},
    {4'h3, 4'h0, 16'h0000, 16'h0000, 12'h040, 12'h040},
    {4'h0, 4'h0, 16'h0005, 16'h03E8, 12'h005, 12'h3E8},
    {4'h0, 4'h0, 16'h07D0, 16'h03FF, 12'h3FF, 12'h3FF},
    {4'h0, 4'h1, 16'h0123, 16'h02AA, 12'h123, 12'h2AA},
    {4'h0, 4'h1, 16'h07FF, 16'h0400, 12'h3FF, 12'h3FF},
    {4'h3, 4'h1, 16'h0000, 16'h0000, 12'h040, 12'h040}
  };

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] s, input logic m);
    @(negedge clk);
    mrst_n = 0; sel = s; serial_mode = m;
    repeat (2) @(negedge clk);
    mrst_n = 1;
    sel = ~s; serial_mode = ~m;  // R9: later changes ignored
  endtask

  task automatic par_write(input logic [DW-1:0] v);
    wr_en = 1; wr_data = v;
    @(negedge clk);
    wr_en = 0; wr_data = '0;
  endtask

  task automatic ser_shift(input logic [SW-1:0] v);
    for (int i = SW - 1; i >= 0; i--) begin
      ser_en = 1; ser_din = v[i];
      @(negedge clk);
    end
    ser_en = 0; ser_din = 0;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) begin
      logic [3:0] s, m;
      logic [15:0] a, f;
      logic [11:0] ea, ef;
      {s, m, a, f, ea, ef} = VEC[k];
      do_reset(s[1:0], m[0]);
      if (s != 0) begin
        check("R1 preset done", load_done, 1);
        check("R1 preset ae", ae_off, ea);
        check("R1 preset af", af_off, ef);
      end else begin
        check("R1 program done low", load_done, 0);
        check("R1 program ae zero", ae_off, 0);
        if (m == 0) begin
          par_write(a);
          check("R2 ae after first write", ae_off, ea);
          check("R2 not done after one write", load_done, 0);
          par_write(f);
        end else begin
          ser_shift(a[SW-1:0]);
          check("R3 ae after first field", ae_off, ea);
          check("R3 not done mid-load", load_done, 0);
          ser_shift(f[SW-1:0]);
        end
        check("R2/R3 done", load_done, 1);
        check("R4 ae value", ae_off, ea);
        check("R4 af value", af_off, ef);
      end
    end

    // R5/R7: writes after done pass through, offsets locked
    do_reset(2'b00, 1'b0);
    wr_en = 1; #1;
    check("R5 write blocked before done", wr_allow, 0);
    wr_en = 0;
    par_write(36'd30); par_write(36'd900);
    wr_en = 1; wr_data = 36'd5; #1;
    check("R5 write passed after done", wr_allow, 1);
    ser_en = 1; ser_din = 1;
    repeat (3) @(negedge clk);
    wr_en = 0; ser_en = 0;
    check("R7 ae locked", ae_off, 30);
    check("R7 af locked", af_off, 900);

    // R6: partial reset after done
    prst_n = 0; wr_en = 1; #1;
    check("R5 write blocked in flush", wr_allow, 0);
    @(negedge clk); @(negedge clk);
    prst_n = 1; wr_en = 0;
    check("R6 ae kept", ae_off, 30);
    check("R6 af kept", af_off, 900);
    check("R6 done kept", load_done, 1);

    // R6: partial reset mid parallel load
    do_reset(2'b00, 1'b0);
    par_write(36'd7);
    prst_n = 0;
    par_write(36'd9);
    prst_n = 1;
    check("R6 mid-load done held", load_done, 0);
    check("R6 mid-load ae held", ae_off, 7);
    par_write(36'd20);
    check("R6 resumed af", af_off, 20);
    check("R6 resumed done", load_done, 1);

    // R8: serial strobe ignored in parallel mode
    do_reset(2'b00, 1'b0);
    ser_en = 1; ser_din = 1;
    repeat (2 * SW + 2) @(negedge clk);
    ser_en = 0;
    check("R8 parallel ignores ser_en done", load_done, 0);
    check("R8 parallel ignores ser_en ae", ae_off, 0);

    // R8: write strobe ignored in serial mode
    do_reset(2'b00, 1'b1);
    par_write(36'd11); par_write(36'd12); par_write(36'd13);
    check("R8 serial ignores wr_en done", load_done, 0);
    check("R8 serial ignores wr_en ae", ae_off, 0);
    ser_shift(11'd3); ser_shift(11'd4);
    check("R8 serial ae", ae_off, 3);
    check("R9 serial af after mode flip", af_off, 4);

    finished = 1;
    summary();
  end
endmodule